// File: doc/BRIEF.md
# Two-Axis Bit Array Memory

This block is a square storage array of N words, each N bits wide. The same bits can be reached along several directions, and the direction is chosen on each access by a 2-bit mode input. Word-slice access moves a whole word for transfers in and out of the array. Bit-slice access moves one bit position of every word at once, as a parallel processing array needs. Two byte-oriented modes reach strided groups of bytes or of bits within bytes. Every access moves exactly N bits over one read bus and one write bus, and a per-bit mask selects which bus positions a write touches.

Reads are registered. The read bus shows the slice that the mode and address named at the previous clock edge. A write takes effect on the rising edge at which the write enable is high. A read of the cells that the same edge writes returns their contents from before the write. N must be a power of two and at least 8. The full-size configuration is 256. The default is smaller so that the register model stays light in simulation.

Top module: `mda_memory`

## Requirements
- R1: A synchronous active-high reset clears every storage bit and the read bus to zero.
- R2: Mode 2'b00 (word-slice): the address is a word index w, and bus bit j corresponds to bit j of word w.
- R3: Mode 2'b01 (bit-slice): the address is a bit index b, and bus bit i corresponds to bit b of word i.
- R4: Mode 2'b10 (one byte of a group of records): the address upper 3 bits give a group g and the low log2(N/8) bits give a byte index k. Bus bit 8*r+t corresponds to bit 8*k+t of word g*(N/8)+r.
- R5: Mode 2'b11 (one bit of each byte): the address low 3 bits give a bit t within a byte and the upper bits give a group g of 8 words. Bus bit (N/8)*r+k corresponds to bit 8*k+t of word 8*g+r.
- R6: The read bus shows the addressed slice one clock after mode and address are presented, and keeps its value until the next edge.
- R7: With write enable low, no storage bit changes, whatever the write bus, mask, mode and address are.
- R8: A bus position whose mask bit is 0 leaves its cell unchanged during a write. A position whose mask bit is 1 takes the write-bus value.
- R9: When a read and a write name the same cells on the same edge, the read bus returns the data from before the write.
- R10: In every mode and address the slice maps one-to-one onto exactly N distinct cells, so a full-mask write of all ones into cleared storage sets exactly N bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 2 | Access direction code (see R2 to R5) |
| acc_addr | input | log2(N) | Slice address, interpreted per mode |
| wr_en | input | 1 | Write enable for the current edge |
| wr_data | input | N | Write bus, one bit per slice position |
| wr_mask | input | N | Per-position write mask, 1 = write |
| rd_data | output | N | Registered read bus |

## Verification
The assertions check on every cycle that the write decode hits exactly N cells, that no bit changes without a write enable, that a write changes at most as many bits as its mask allows, that the read bus is cleared after reset, and that it holds still while mode, address and storage do not change. They cannot tell whether a slice reaches the right cells in the right bus order. The bench's scenarios show that by writing along one direction and reading back along another, against its own model of the four mappings. The scenarios also cover the one-cycle read timing, the masked writes and the old-data result on a same-edge read and write.

// File: rtl/mda_pkg.sv
package mda_pkg;

    typedef enum logic [1:0] {
        MODE_WORD     = 2'b00,
        MODE_BIT      = 2'b01,
        MODE_BYTE_GRP = 2'b10,
        MODE_BIT_BYTE = 2'b11
    } mda_mode_e;

    // A storage coordinate: word (row) and bit within word (col)
    typedef struct packed {
        logic [15:0] row;
        logic [15:0] col;
    } cell_ref_t;

    // Where a storage cell lands on the slice bus, if it is selected
    typedef struct packed {
        logic        hit;
        logic [15:0] pos;
    } bus_ref_t;

    // Forward map: slice bus position -> storage cell
    function automatic cell_ref_t slice_to_cell(
        input mda_mode_e   m,
        input logic [15:0] a,
        input logic [15:0] p,
        input int          lg_n
    );
        cell_ref_t   res;
        logic [15:0] nb_m;
        int          kb;
        kb   = lg_n - 3;
        nb_m = (16'd1 << kb) - 16'd1;
        case (m)
            MODE_WORD: begin
                res.row = a;
                res.col = p;
            end
            MODE_BIT: begin
                res.row = p;
                res.col = a;
            end
            MODE_BYTE_GRP: begin
                res.row = ((a >> kb) << kb) | (p >> 3);
                res.col = ((a & nb_m) << 3) | (p & 16'd7);
            end
            default: begin
                res.row = ((a >> 3) << 3) | (p >> kb);
                res.col = ((p & nb_m) << 3) | (a & 16'd7);
            end
        endcase
        return res;
    endfunction

    // Inverse map: storage cell -> slice bus position
    function automatic bus_ref_t cell_to_slice(
        input mda_mode_e   m,
        input logic [15:0] a,
        input logic [15:0] i,
        input logic [15:0] j,
        input int          lg_n
    );
        bus_ref_t    res;
        logic [15:0] nb_m;
        int          kb;
        kb   = lg_n - 3;
        nb_m = (16'd1 << kb) - 16'd1;
        case (m)
            MODE_WORD: begin
                res.hit = (i == a);
                res.pos = j;
            end
            MODE_BIT: begin
                res.hit = (j == a);
                res.pos = i;
            end
            MODE_BYTE_GRP: begin
                res.hit = ((i >> kb) == (a >> kb)) && ((j >> 3) == (a & nb_m));
                res.pos = ((i & nb_m) << 3) | (j & 16'd7);
            end
            default: begin
                res.hit = ((i >> 3) == (a >> 3)) && ((j & 16'd7) == (a & 16'd7));
                res.pos = ((i & 16'd7) << kb) | (j >> 3);
            end
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mda_read_steer.sv
module mda_read_steer
    import mda_pkg::*;
#(
    parameter int N   = 32,
    parameter int LGN = 5
) (
    input  mda_mode_e          mode,
    input  logic [LGN-1:0]     addr,
    input  logic [N*N-1:0]     mem_flat,
    output logic [N-1:0]       slice
);
    localparam int IW = 2 * LGN;

    for (genvar p = 0; p < N; p++) begin : g_pos
        cell_ref_t      cref;
        logic [IW-1:0]  idx;
        assign cref  = slice_to_cell(mode, 16'(addr), 16'(p), LGN);
        assign idx   = {cref.row[LGN-1:0], cref.col[LGN-1:0]};
        assign slice[p] = mem_flat[idx];
    end

endmodule

// File: rtl/mda_write_steer.sv
module mda_write_steer
    import mda_pkg::*;
#(
    parameter int N   = 32,
    parameter int LGN = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  mda_mode_e          mode,
    input  logic [LGN-1:0]     addr,
    input  logic               wr_en,
    input  logic [N-1:0]       wr_data,
    input  logic [N-1:0]       wr_mask,
    output logic [N*N-1:0]     cell_we,
    output logic [N*N-1:0]     cell_d
);
    logic [N*N-1:0] hit_flat;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            bus_ref_t       bref;
            logic [LGN-1:0] bp;
            assign bref = cell_to_slice(mode, 16'(addr), 16'(i), 16'(j), LGN);
            assign bp   = bref.pos[LGN-1:0];
            assign hit_flat[i*N+j] = bref.hit;
            assign cell_we[i*N+j]  = wr_en & bref.hit & wr_mask[bp];
            assign cell_d[i*N+j]   = wr_data[bp];
        end
    end

    // R10
    decode_covers_n_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_flat) == N);

endmodule

// File: rtl/mda_bit_array.sv
module mda_bit_array #(
    parameter int N = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N*N-1:0]     cell_we,
    input  logic [N*N-1:0]     cell_d,
    output logic [N*N-1:0]     mem_flat
);
    logic [N*N-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            mem_q <= (mem_q & ~cell_we) | (cell_d & cell_we);
        end
    end

    assign mem_flat = mem_q;

endmodule

// File: rtl/mda_memory.sv
module mda_memory
    import mda_pkg::*;
#(
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     acc_mode,
    input  logic [AW-1:0]  acc_addr,
    input  logic           wr_en,
    input  logic [N-1:0]   wr_data,
    input  logic [N-1:0]   wr_mask,
    output logic [N-1:0]   rd_data
);
    mda_mode_e      mode;
    logic [N*N-1:0] mem_flat;
    logic [N*N-1:0] cell_we;
    logic [N*N-1:0] cell_d;
    logic [N-1:0]   slice;
    logic [N-1:0]   rd_q;

    assign mode = mda_mode_e'(acc_mode);

    mda_write_steer #(.N(N), .LGN(AW)) u_wsteer (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .addr    (acc_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .cell_we (cell_we),
        .cell_d  (cell_d)
    );

    mda_bit_array #(.N(N)) u_array (
        .clk      (clk),
        .rst      (rst),
        .cell_we  (cell_we),
        .cell_d   (cell_d),
        .mem_flat (mem_flat)
    );

    mda_read_steer #(.N(N), .LGN(AW)) u_rsteer (
        .mode     (mode),
        .addr     (acc_addr),
        .mem_flat (mem_flat),
        .slice    (slice)
    );

    // Read register samples pre-write storage: same-edge reads see old data
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= slice;
        end
    end

    assign rd_data = rd_q;

    // R1
    reset_clears_rd_chk: assert property (@(posedge clk)
        rst |=> rd_data == '0);

    // R7
    no_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_flat));

    // R8
    mask_bounds_change_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $countones(mem_flat ^ $past(mem_flat)) <= $countones($past(wr_mask)));

    // R6
    read_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && $stable(acc_mode) && $stable(acc_addr)) |=> $stable(rd_data));

endmodule

// File: tb/tb_mda_memory.sv
module tb_mda_memory;
    localparam int N  = 32;
    localparam int AW = $clog2(N);
    localparam int NB = N / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    acc_mode = 2'b00;
    logic [AW-1:0] acc_addr = '0;
    logic          wr_en = 1'b0;
    logic [N-1:0]  wr_data = '0;
    logic [N-1:0]  wr_mask = '0;
    logic [N-1:0]  rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [N-1:0] mdl [N];

    always #10 clk = ~clk;

    mda_memory #(.N(N)) dut (
        .clk      (clk),
        .rst      (rst),
        .acc_mode (acc_mode),
        .acc_addr (acc_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .rd_data  (rd_data)
    );

    function automatic void locate(input int m, input int a, input int p,
                                   output int r, output int c);
        case (m)
            0: begin r = a; c = p; end
            1: begin r = p; c = a; end
            2: begin r = (a / NB) * NB + p / 8; c = 8 * (a % NB) + p % 8; end
            default: begin r = 8 * (a / 8) + p / NB; c = 8 * (p % NB) + a % 8; end
        endcase
    endfunction

    function automatic logic [N-1:0] expect_slice(input int m, input int a);
        logic [N-1:0] v;
        int r, c;
        for (int p = 0; p < N; p++) begin
            locate(m, a, p, r, c);
            v[p] = mdl[r][c];
        end
        return v;
    endfunction

    function automatic logic [N-1:0] rnd_vec();
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = 1'($urandom % 2);
        return v;
    endfunction

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_model();
        for (int r = 0; r < N; r++) mdl[r] = '0;
    endtask

    task automatic do_write(input int m, input int a, input logic [N-1:0] d,
                            input logic [N-1:0] msk);
        int r, c;
        @(negedge clk);
        acc_mode = 2'(m);
        acc_addr = a[AW-1:0];
        wr_data  = d;
        wr_mask  = msk;
        wr_en    = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        for (int p = 0; p < N; p++) begin
            if (msk[p]) begin
                locate(m, a, p, r, c);
                mdl[r][c] = d[p];
            end
        end
    endtask

    task automatic do_read(input string req, input int m, input int a);
        logic [N-1:0] exp;
        @(negedge clk);
        acc_mode = 2'(m);
        acc_addr = a[AW-1:0];
        wr_en    = 1'b0;
        exp = expect_slice(m, a);
        @(posedge clk);
        @(negedge clk);
        check(req, rd_data, exp);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    // R1: storage and read bus cleared by reset
    task automatic t_reset();
        do_write(0, 3, rnd_vec(), '1);
        do_write(1, 9, rnd_vec(), '1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 rd_data", rd_data, '0);
        rst = 1'b0;
        clear_model();
        for (int w = 0; w < N; w += 3) do_read("R1 word", 0, w);
    endtask

    // R2: word-slice write and read
    task automatic t_word();
        for (int w = 0; w < N; w++) do_write(0, w, rnd_vec(), '1);
        do_read("R2", 0, 0);
        do_read("R2", 0, N - 1);
        do_read("R2", 0, 13);
    endtask

    // R3: bit-slice reads of word data, bit-slice write seen in words
    task automatic t_bit();
        do_read("R3", 1, 0);
        do_read("R3", 1, N - 1);
        do_read("R3", 1, 6);
        do_write(1, 17, rnd_vec(), '1);
        do_read("R3", 1, 17);
        do_read("R3 via word", 0, 4);
        do_read("R3 via word", 0, N - 2);
    endtask

    // R4: byte of a group of records
    task automatic t_byte_grp();
        do_write(2, 0, rnd_vec(), '1);
        do_write(2, N - 1, rnd_vec(), '1);
        do_read("R4", 2, 0);
        do_read("R4", 2, N - 1);
        do_read("R4", 2, 5);
        do_read("R4 via word", 0, 0);
        do_read("R4 via word", 0, N - 1);
        do_read("R4 via bit", 1, 3);
    endtask

    // R5: one bit of each byte
    task automatic t_bit_byte();
        do_write(3, 0, rnd_vec(), '1);
        do_write(3, N - 1, rnd_vec(), '1);
        do_read("R5", 3, 0);
        do_read("R5", 3, N - 1);
        do_read("R5", 3, 10);
        do_read("R5 via word", 0, 2);
        do_read("R5 via word", 0, N - 3);
        do_read("R5 via bytes", 2, 7);
    endtask

    // R6: output changes only after the edge that samples the address
    task automatic t_latency();
        logic [N-1:0] exp_a, exp_b;
        exp_a = expect_slice(0, 1);
        exp_b = expect_slice(0, 2);
        do_read("R6 first", 0, 1);
        @(negedge clk);
        acc_addr = AW'(2);
        #5;
        check("R6 before edge", rd_data, exp_a);
        @(posedge clk);
        #3;
        check("R6 after edge", rd_data, exp_b);
    endtask

    // R7: write bus ignored with enable low
    task automatic t_no_enable();
        @(negedge clk);
        acc_mode = 2'b01;
        acc_addr = AW'(4);
        wr_data  = '1;
        wr_mask  = '1;
        wr_en    = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_data = '0;
        do_read("R7 bit", 1, 4);
        do_read("R7 word", 0, 8);
    endtask

    // R8: masked writes in every mode
    task automatic t_mask();
        for (int m = 0; m < 4; m++) begin
            do_write(m, 6, rnd_vec(), rnd_vec());
            do_write(m, 6, '1, 32'h0000_F00F);
            do_read("R8", m, 6);
            do_write(m, 6, '0, '0);
            do_read("R8 zero mask", m, 6);
        end
        do_read("R8 cross", 0, 6);
        do_read("R8 cross", 1, 6);
    endtask

    // R9: same-edge read and write returns old data
    task automatic t_rdw();
        logic [N-1:0] old_v, new_v;
        int r, c;
        old_v = expect_slice(2, 9);
        new_v = ~old_v;
        @(negedge clk);
        acc_mode = 2'b10;
        acc_addr = AW'(9);
        wr_data  = new_v;
        wr_mask  = '1;
        wr_en    = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        for (int p = 0; p < N; p++) begin
            locate(2, 9, p, r, c);
            mdl[r][c] = new_v[p];
        end
        @(negedge clk);
        check("R9 old data", rd_data, old_v);
        do_read("R9 new data", 2, 9);
    endtask

    // R10: a full write touches exactly N cells
    task automatic t_cover();
        int ones;
        for (int m = 0; m < 4; m++) begin
            apply_reset();
            do_write(m, N / 2 + m, '1, '1);
            ones = 0;
            for (int w = 0; w < N; w++) begin
                do_read("R10 word", 0, w);
                ones += $countones(rd_data);
            end
            n_chk++;
            if (ones != N) begin
                n_fail++;
                $display("FAIL R10: mode %0d got %0d ones expected %0d", m, ones, N);
            end
        end
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word();
        t_bit();
        t_byte_grp();
        t_bit_byte();
        t_latency();
        t_no_enable();
        t_mask();
        t_rdw();
        t_cover();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule